// File: doc/BRIEF.md
# Serial Configuration Command Port

This block is a synchronous serial slave for a converter's control path. A host selects the block with an active-low chip select and then sends 16-bit frames, most significant bit first, on a data line. Each bit is taken on a rising edge of a host-driven serial clock. The block samples the serial clock, chip select and data line into its own system clock domain through synchronizer stages, and it uses an edge detector to find the serial clock's rising edges. The host may stop the serial clock for any length of time partway through a frame and resume later. Frame position is held for as long as chip select stays low.

The first four bits of a frame form a command nibble:

- Values 0 to 7 select an analog channel.
- Values 0xB to 0xD select a test input.
- 0x8 reads the configuration.
- 0xA writes the configuration.

A write loads the 12 bits that follow the nibble into the configuration register, as one update on the 16th rising edge. The nibble itself is never stored. A read shifts the register back out, but only while the conversion-mode field allows it. Otherwise the read returns zeros and sets a sticky error flag. A conversion command produces a one-cycle sampling-start strobe as soon as its nibble is complete. The register is cleared only by the power-up reset.

The controller has six states:

- `ST_IDLE`: deselected.
- `ST_HDR`: collecting the nibble.
- `ST_WR`: collecting write data.
- `ST_RD`: shifting out read data.
- `ST_PASS`: the remaining bits of any other command.
- `ST_DONE`: frame complete.

The transitions are:

- *select*: IDLE to HDR, on chip select low.
- *decode-write*, *decode-read* and *decode-other*: HDR to WR, RD or PASS, on the 4th edge.
- *frame-end*: WR, RD or PASS to DONE, on the 16th edge.
- *deselect*: any state to IDLE, on chip select high.

Top module: `cfgif_top`

## Requirements
- R1: After reset, `cfg` is 0, `sdo` is 0, `rd_err` is 0 and `sample_start` is 0.
- R2: A frame whose first nibble is 4'b1010 (0xA) loads the next 12 bits (frame bits 11..0, MSB first) into `cfg`, all at once on the 16th rising edge; the nibble is not stored.
- R3: If the serial clock stops after 8 bits for any duration with chip select held low, the remaining 8 bits complete the same frame when the clock resumes.
- R4: A frame with nibble 4'b1000 (0x8), while `cfg[6:5]` is 2'b00, drives `cfg[11]` down to `cfg[0]` on `sdo`; bit 11-k is valid before rising edge 5+k (k = 0..11).
- R5: A read nibble 0x8 while `cfg[6:5]` is not 2'b00 drives `sdo` low for the whole frame and sets `rd_err`. The flag stays set until reset.
- R6: `sample_start` pulses for exactly one clock after the 4th rising edge when the nibble is 0x0 to 0x7 or 0xB to 0xD, and never for 0x8, 0x9, 0xA, 0xE or 0xF.
- R7: Raising `cs_n` before the 16th edge aborts the frame without changing `cfg`; the next frame decodes its nibble from its first bit.
- R8: Rising edges after the 16th, with `cs_n` still low, leave `cfg` unchanged.
- R9: Frames with any nibble other than 0xA leave `cfg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out for reads |
| cfg | output | 12 | Configuration register |
| sample_start | output | 1 | One-cycle sampling-start strobe |
| rd_err | output | 1 | Sticky flag for a refused read |

## Verification
The bench walks all sixteen command nibbles and counts strobes per frame. A decoder with a shifted range would miss the test inputs or fire on the reserved codes. Reads are tried under each of the four mode-field values. A wrong gate would leak register data in the repeat and sweep modes, or would clear the error flag again. A frame cut off after 15 bits, a frame with a long clock pause after 8 bits, and a frame with surplus edges each target a counter that resets too early, loses its position, or writes twice. Write values are chosen so that every data bit toggles, which catches any slip of one in the bit ordering.

// File: rtl/cfgif_pkg.sv
package cfgif_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR,
        ST_RD,
        ST_PASS,
        ST_DONE
    } cfgif_state_e;

    localparam logic [3:0] CMD_RDCFG   = 4'h8;
    localparam logic [3:0] CMD_WRCFG   = 4'hA;
    localparam logic [3:0] CMD_TEST_LO = 4'hB;
    localparam logic [3:0] CMD_TEST_HI = 4'hD;
endpackage

// File: rtl/cfgif_sync.sv
module cfgif_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgif_decode.sv
module cfgif_decode
    import cfgif_pkg::*;
#(
    parameter int CMD_W = 4
) (
    input  logic [CMD_W-1:0] cmd,
    output logic             is_conv,
    output logic             is_rd,
    output logic             is_wr
);
    logic is_chan, is_test;

    always_comb begin
        is_chan = (cmd[CMD_W-1] == 1'b0);
        is_test = (cmd >= CMD_W'(CMD_TEST_LO)) && (cmd <= CMD_W'(CMD_TEST_HI));
        is_conv = is_chan || is_test;
        is_rd   = (cmd == CMD_W'(CMD_RDCFG));
        is_wr   = (cmd == CMD_W'(CMD_WRCFG));
    end
endmodule

// File: rtl/cfgif_top.sv
module cfgif_top
    import cfgif_pkg::*;
#(
    parameter int CFG_W       = 12,
    parameter int CMD_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MODE_LSB    = 5,
    parameter int MODE_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic             sdo,
    output logic [CFG_W-1:0] cfg,
    output logic             sample_start,
    output logic             rd_err
);
    localparam int FRAME_W = CMD_W + CFG_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic sclk_s, cs_s, sdi_s, sclk_prev;
    logic rise;
    cfgif_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] cmd_sr, cmd_next;
    logic [CFG_W-1:0] data_sr, out_sr;
    logic is_conv, is_rd, is_wr;
    logic hdr_done, wr_fire, last_edge, rd_ok;

    cfgif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, sdi}),
        .q    ({sclk_s, cs_s, sdi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign rise      = sclk_s && !sclk_prev && !cs_s;
    assign cmd_next  = {cmd_sr[CMD_W-2:0], sdi_s};
    assign hdr_done  = rise && (state == ST_HDR) && (cnt == CNT_W'(CMD_W - 1));
    assign last_edge = rise && (cnt == CNT_W'(FRAME_W - 1));
    assign wr_fire   = last_edge && (state == ST_WR);
    assign rd_ok     = (cfg[MODE_LSB +: MODE_W] == '0);

    cfgif_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd    (cmd_next),
        .is_conv(is_conv),
        .is_rd  (is_rd),
        .is_wr  (is_wr)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_HDR;
            ST_HDR: begin
                if (hdr_done) begin
                    if (is_wr)      nxt = ST_WR;
                    else if (is_rd) nxt = ST_RD;
                    else            nxt = ST_PASS;
                end
            end
            ST_WR, ST_RD, ST_PASS: if (last_edge) nxt = ST_DONE;
            ST_DONE: nxt = ST_DONE;
        endcase
        if (cs_s) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            cmd_sr       <= '0;
            data_sr      <= '0;
            out_sr       <= '0;
            cfg          <= '0;
            sample_start <= 1'b0;
            rd_err       <= 1'b0;
        end else begin
            sample_start <= hdr_done && is_conv;
            if (cs_s) begin
                cnt <= '0;
            end else if (rise && cnt < CNT_W'(FRAME_W)) begin
                cnt <= cnt + 1'b1;
            end
            if (rise && state == ST_HDR) cmd_sr <= cmd_next;
            if (rise && state == ST_WR)  data_sr <= {data_sr[CFG_W-2:0], sdi_s};
            if (wr_fire) cfg <= {data_sr[CFG_W-2:0], sdi_s};
            if (hdr_done && is_rd) begin
                out_sr <= rd_ok ? cfg : '0;
                if (!rd_ok) rd_err <= 1'b1;
            end else if (rise && state == ST_RD) begin
                out_sr <= {out_sr[CFG_W-2:0], 1'b0};
            end
        end
    end

    assign sdo = (state == ST_RD) ? out_sr[CFG_W-1] : 1'b0;

    assert_strobe_at_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start |-> (cnt == CNT_W'(CMD_W)));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(cfg));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err);

    assert_deselect_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state == ST_IDLE && cnt == '0));

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_W));
endmodule

// File: tb/test_cfgif_top.sv
module test_cfgif_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sample_start, rd_err;
    logic [11:0] cfg;

    int checks = 0, errors = 0, strobes = 0;
    bit finished = 0;
    logic [11:0] cfg_model = '0;
    logic err_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgif_top i_cfgif_top (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .cfg(cfg), .sample_start(sample_start), .rd_err(rd_err)
    );

    always @(posedge clk) if (sample_start) strobes++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, input int extra,
                         input bit pause, output logic [11:0] rd, output int nstrobe);
        int s0;
        s0 = strobes;
        rd = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits + extra; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b1;
            wait_clk(HALF);
            if (i >= 4 && i < 16) rd[15-i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            if (pause && i == 7) wait_clk(300);
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
        nstrobe = strobes - s0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] rd, v;
        int ns;
        wait_clk(4);
        check(cfg == 0 && sdo == 0, "R1 reset cfg/sdo", cfg, 0);
        check(rd_err == 0 && sample_start == 0, "R1 reset flags", rd_err, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R2 / R4 / R5: write each mode value, read back
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                v = (p == 0) ? 12'hA95 : 12'h56A;
                v[6:5] = m[1:0];
                frame({4'hA, v}, 16, 0, 0, rd, ns);
                cfg_model = v;
                check(cfg == cfg_model, "R2 write", cfg, cfg_model);
                frame({4'h8, 12'h000}, 16, 0, 0, rd, ns);
                if (m != 0) err_model = 1'b1;
                if (m == 0) check(rd == cfg_model, "R4 read back", rd, cfg_model);
                else        check(rd == 0, "R5 refused read zero", rd, 0);
                check(rd_err == err_model, "R5 sticky flag", rd_err, err_model);
                check(cfg == cfg_model, "R9 read leaves cfg", cfg, cfg_model);
            end
        end

        // R7: abort after 15 bits, then a fresh full frame
        frame({4'hA, 12'h3C3}, 15, 0, 0, rd, ns);
        check(cfg == cfg_model, "R7 abort no write", cfg, cfg_model);
        frame({4'hA, 12'h018}, 16, 0, 0, rd, ns);
        cfg_model = 12'h018;
        check(cfg == cfg_model, "R7 next frame aligned", cfg, cfg_model);

        // R3: pause after 8 bits
        frame({4'hA, 12'hF87}, 16, 0, 1, rd, ns);
        cfg_model = 12'hF87;
        check(cfg == cfg_model, "R3 paused write", cfg, cfg_model);

        // R8: extra edges after 16
        frame({4'hA, 12'h001}, 16, 5, 0, rd, ns);
        cfg_model = 12'h001;
        check(cfg == cfg_model, "R8 extra edges ignored", cfg, cfg_model);

        // R6 / R9: sweep all command nibbles with data of all ones
        for (int c = 0; c < 16; c++) begin
            int exp_s;
            logic [11:0] d;
            d = (c == 10) ? cfg_model : 12'hFFF;
            frame({c[3:0], d}, 16, 0, 0, rd, ns);
            exp_s = (c < 8 || (c >= 11 && c <= 13)) ? 1 : 0;
            check(ns == exp_s, $sformatf("R6 strobe cmd %0h", c), ns, exp_s);
            check(cfg == cfg_model, $sformatf("R9 cmd %0h cfg kept", c), cfg, cfg_model);
        end
        check(rd_err == err_model, "R5 flag still set", rd_err, err_model);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule